// File: doc/BRIEF.md
# Analog TV Field Timing Sequencer

This block produces the timing of a two-field, 625-line-style analog television signal as a stream of 3-bit drive codes. Each field starts with a group of short equalizing pulse pairs, continues with broad vertical-sync pulse pairs and a second group of equalizing pairs, and then carries a long run of active lines. Each active line holds a horizontal sync tip, a blanking interval, a run of picture slots and a short blanking interval before the next line. Code 0 is the sync level and code 1 is the blanking level. Picture slots carry codes from 1 to 7.

The sequencer moves forward one microsecond slot for each cycle in which the tick enable is high. When it enters a picture slot it raises a one-cycle request toward an external sample source. In that same cycle it takes a signed sample, folds the sample's magnitude onto the drive code and presents the result one clock later. If no valid sample is offered, the default code is used. The amplitude, line-start, field-start and field-index outputs all come from one output register. They change on the clock edge after the tick that enters a slot, and they hold until the next slot is entered. After the second field the sequence goes back to the first field at once.

Top module: `atv_field_seq`

## Requirements
- R1: While the synchronous reset is high, the tick input is ignored. On the clock after reset the sequencer sits on the first sync slot of field 0, `amp_o` is 0, `field_o` is 0, and `smp_req_o`, `line_start_o` and `field_start_o` are all low.
- R2: Position changes only on a clock edge where `tick_i` is high. `amp_o` takes the level of the newly entered slot on the following edge and holds that value until the next slot is entered.
- R3: Each field opens with equalizing pairs: 5 in field 0 and 6 in field 1. Each pair is 2 slots at code 0 followed by 30 slots at code 1.
- R4: Next come 5 broad pairs, each 27 slots at code 0 followed by 5 slots at code 1.
- R5: Next come 5 more equalizing pairs, each 2 slots at code 0 followed by 30 slots at code 1.
- R6: Each field ends with 305 active lines of 64 slots each: 4 slots at code 0, 6 slots at code 1, 52 picture slots, then 2 slots at code 1.
- R7: `smp_req_o` is high for exactly one clock on the edge after each tick that enters a picture slot. This gives 52 requests per line and 15860 per field.
- R8: With `smp_valid_i` high during a request, the picture code is round-half-up(|s|·6/64)+1, clamped to 7. Here s is the 8-bit two's-complement `smp_i`, and ±64 is full scale.
- R9: With `smp_valid_i` low during a request, the picture code is 3. Sample inputs outside request cycles have no effect.
- R10: `line_start_o` pulses for one clock together with the first sync slot of each active line. `field_start_o` pulses with the first slot of each field, but not on leaving reset. `field_o` gives the index of the field being output.
- R11: Field 0 lasts 20000 slots and field 1 lasts 20032 slots. The last slot of field 1 is followed directly by the first slot of field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Advance one microsecond slot |
| smp_valid_i | input | 1 | `smp_i` holds a fresh sample |
| smp_i | input | 8 | Signed picture sample, ±64 is full scale |
| smp_req_o | output | 1 | One-clock request: a picture slot has been entered |
| amp_o | output | 3 | Drive code (0 sync, 1 blanking, 1..7 picture) |
| line_start_o | output | 1 | One-clock pulse at the start of each active line |
| field_start_o | output | 1 | One-clock pulse at the start of each field |
| field_o | output | 1 | Index of the field being output |

## Verification
The properties assume several things about the inputs. Reset is synchronous and lasts at least one clock. `tick_i` is a level sampled on each edge, and any pattern of gaps between ticks is allowed. The sample pair only needs to be valid during a request cycle. The stimulus runs with a tick on every clock for more than a whole frame and then with a tick on two clocks out of three for another full frame. It also applies a reset while ticks are still arriving. `smp_valid_i` and `smp_i` change on every clock, including outside request cycles. The samples include exact half-step values, both full-scale signs and the most negative code.

// File: rtl/atvs_pkg.sv
package atvs_pkg;

   typedef enum logic [1:0] {
      SEG_PRE  = 2'd0,
      SEG_BRD  = 2'd1,
      SEG_POST = 2'd2,
      SEG_LINE = 2'd3
   } seg_e;

   typedef enum logic [1:0] {
      LVL_SYNC  = 2'd0,
      LVL_BLANK = 2'd1,
      LVL_PIX   = 2'd2
   } lvl_e;

   localparam logic [2:0] CODE_SYNC  = 3'd0;
   localparam logic [2:0] CODE_BLANK = 3'd1;

endpackage

// File: rtl/atvs_pos_ctr.sv
module atvs_pos_ctr
   import atvs_pkg::*;
#(
   parameter int EQ_LO   = 2,
   parameter int EQ_HI   = 30,
   parameter int BR_LO   = 27,
   parameter int BR_HI   = 5,
   parameter int PRE_F0  = 5,
   parameter int PRE_F1  = 6,
   parameter int BRD_N   = 5,
   parameter int POST_N  = 5,
   parameter int LINES   = 305,
   parameter int LINE_US = 64,
   parameter int UW      = 6,
   parameter int GW      = 9
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          tick_i,
   output seg_e          seg_o,
   output logic [GW-1:0] grp_o,
   output logic [UW-1:0] us_o,
   output logic          fld_o,
   output logic          adv_o
);
   localparam int EQ_LEN = EQ_LO + EQ_HI;
   localparam int BR_LEN = BR_LO + BR_HI;

   int   seg_len;
   int   seg_cnt;
   logic last_us;
   logic last_grp;

   // length of the current pair or line, and how many of them the segment holds
   always_comb begin
      unique case (seg_o)
         SEG_PRE:  begin seg_len = EQ_LEN;  seg_cnt = fld_o ? PRE_F1 : PRE_F0; end
         SEG_BRD:  begin seg_len = BR_LEN;  seg_cnt = BRD_N;  end
         SEG_POST: begin seg_len = EQ_LEN;  seg_cnt = POST_N; end
         default:  begin seg_len = LINE_US; seg_cnt = LINES;  end
      endcase
      last_us  = (int'(us_o) == seg_len - 1);
      last_grp = (int'(grp_o) == seg_cnt - 1);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         seg_o <= SEG_PRE;
         grp_o <= '0;
         us_o  <= '0;
         fld_o <= 1'b0;
         adv_o <= 1'b0;
      end else begin
         adv_o <= tick_i;
         if (tick_i) begin
            if (!last_us) begin
               us_o <= us_o + UW'(1);
            end else begin
               us_o <= '0;
               if (!last_grp) begin
                  grp_o <= grp_o + GW'(1);
               end else begin
                  grp_o <= '0;
                  unique case (seg_o)
                     SEG_PRE:  seg_o <= SEG_BRD;
                     SEG_BRD:  seg_o <= SEG_POST;
                     SEG_POST: seg_o <= SEG_LINE;
                     default: begin
                        seg_o <= SEG_PRE;
                        fld_o <= ~fld_o;
                     end
                  endcase
               end
            end
         end
      end
   end

endmodule

// File: rtl/atvs_slot_decode.sv
module atvs_slot_decode
   import atvs_pkg::*;
#(
   parameter int EQ_LO = 2,
   parameter int BR_LO = 27,
   parameter int HS    = 4,
   parameter int BP    = 6,
   parameter int PIX   = 52,
   parameter int UW    = 6
) (
   input  seg_e          seg_i,
   input  logic [UW-1:0] us_i,
   output lvl_e          lvl_o
);
   localparam int PIX_FIRST = HS + BP;
   localparam int PIX_END   = PIX_FIRST + PIX;

   int u;

   always_comb begin
      u = int'(us_i);
      unique case (seg_i)
         SEG_PRE, SEG_POST: lvl_o = (u < EQ_LO) ? LVL_SYNC : LVL_BLANK;
         SEG_BRD:           lvl_o = (u < BR_LO) ? LVL_SYNC : LVL_BLANK;
         default: begin
            if (u < HS)             lvl_o = LVL_SYNC;
            else if (u < PIX_FIRST) lvl_o = LVL_BLANK;
            else if (u < PIX_END)   lvl_o = LVL_PIX;
            else                    lvl_o = LVL_BLANK;
         end
      endcase
   end

endmodule

// File: rtl/atvs_code_map.sv
module atvs_code_map #(
   parameter int SW  = 8,
   parameter int FS  = 64,
   parameter int DEF = 3
) (
   input  logic signed [SW-1:0] smp_i,
   input  logic                 valid_i,
   output logic [2:0]           code_o
);
   localparam int PW = SW + 6;

   logic signed [SW:0] ext;
   logic [SW:0]        mag;
   logic [PW-1:0]      num;
   logic [PW-1:0]      q;

   // num = 12*|s| + FS, so num / (2*FS) = floor(6*|s|/FS + 1/2)
   always_comb begin
      ext = {smp_i[SW-1], smp_i};
      mag = ext[SW] ? unsigned'(-ext) : unsigned'(ext);
      num = PW'(mag) * PW'(12) + PW'(FS);
   end

   if ((FS & (FS - 1)) == 0) begin : g_shift
      assign q = num >> ($clog2(FS) + 1);
   end else begin : g_div
      assign q = num / PW'(2 * FS);
   end

   always_comb begin
      if (!valid_i)          code_o = 3'(DEF);
      else if (q >= PW'(6))  code_o = 3'd7;
      else                   code_o = 3'(q + PW'(1));
   end

endmodule

// File: rtl/atv_field_seq.sv
module atv_field_seq
   import atvs_pkg::*;
#(
   parameter int SW         = 8,
   parameter int FS         = 64,
   parameter int DEF_CODE   = 3,
   parameter int EQ_LO_US   = 2,
   parameter int EQ_HI_US   = 30,
   parameter int BR_LO_US   = 27,
   parameter int BR_HI_US   = 5,
   parameter int PRE_F0     = 5,
   parameter int PRE_F1     = 6,
   parameter int BRD_PAIRS  = 5,
   parameter int POST_PAIRS = 5,
   parameter int LINES      = 305,
   parameter int HS_US      = 4,
   parameter int BP_US      = 6,
   parameter int PIX_US     = 52,
   parameter int FP_US      = 2
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          tick_i,
   input  logic          smp_valid_i,
   input  logic [SW-1:0] smp_i,
   output logic          smp_req_o,
   output logic [2:0]    amp_o,
   output logic          line_start_o,
   output logic          field_start_o,
   output logic          field_o
);
   localparam int LINE_US = HS_US + BP_US + PIX_US + FP_US;
   localparam int EQ_LEN  = EQ_LO_US + EQ_HI_US;
   localparam int BR_LEN  = BR_LO_US + BR_HI_US;
   localparam int MAX_A   = (EQ_LEN > BR_LEN) ? EQ_LEN : BR_LEN;
   localparam int MAX_LEN = (MAX_A > LINE_US) ? MAX_A : LINE_US;
   localparam int MAX_P   = (PRE_F0 > PRE_F1) ? PRE_F0 : PRE_F1;
   localparam int MAX_Q   = (BRD_PAIRS > POST_PAIRS) ? BRD_PAIRS : POST_PAIRS;
   localparam int MAX_R   = (MAX_P > MAX_Q) ? MAX_P : MAX_Q;
   localparam int MAX_G   = (MAX_R > LINES) ? MAX_R : LINES;
   localparam int UW      = $clog2(MAX_LEN);
   localparam int GW      = $clog2(MAX_G + 1);

   if (SW < 3 || FS < 1 || FS > (2 ** (SW - 1)) - 1 || DEF_CODE < 0 || DEF_CODE > 7)
   begin : g_bad_sample_cfg
      $error("atv_field_seq: sample width, full scale or default code out of range");
   end
   if (EQ_LO_US < 1 || EQ_HI_US < 1 || BR_LO_US < 1 || BR_HI_US < 1 || HS_US < 1 ||
       PRE_F0 < 1 || PRE_F1 < 1 || BRD_PAIRS < 1 || POST_PAIRS < 1 || LINES < 1 ||
       PIX_US < 1 || MAX_LEN < 2)
   begin : g_bad_timing_cfg
      $error("atv_field_seq: every timing span and count must be at least one");
   end

   seg_e          seg;
   logic [GW-1:0] grp;
   logic [UW-1:0] us;
   logic          fld;
   logic          adv_q;
   lvl_e          lvl;
   logic [2:0]    pix_code;

   atvs_pos_ctr #(
      .EQ_LO(EQ_LO_US), .EQ_HI(EQ_HI_US), .BR_LO(BR_LO_US), .BR_HI(BR_HI_US),
      .PRE_F0(PRE_F0), .PRE_F1(PRE_F1), .BRD_N(BRD_PAIRS), .POST_N(POST_PAIRS),
      .LINES(LINES), .LINE_US(LINE_US), .UW(UW), .GW(GW)
   ) i_pos (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .tick_i(tick_i),
      .seg_o (seg),
      .grp_o (grp),
      .us_o  (us),
      .fld_o (fld),
      .adv_o (adv_q)
   );

   atvs_slot_decode #(
      .EQ_LO(EQ_LO_US), .BR_LO(BR_LO_US), .HS(HS_US), .BP(BP_US),
      .PIX(PIX_US), .UW(UW)
   ) i_dec (
      .seg_i(seg),
      .us_i (us),
      .lvl_o(lvl)
   );

   atvs_code_map #(
      .SW(SW), .FS(FS), .DEF(DEF_CODE)
   ) i_map (
      .smp_i  (smp_i),
      .valid_i(smp_valid_i),
      .code_o (pix_code)
   );

   assign smp_req_o = adv_q && (lvl == LVL_PIX);

   // output stage: one register for every signal that marks the slot just entered
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         amp_o         <= CODE_SYNC;
         line_start_o  <= 1'b0;
         field_start_o <= 1'b0;
         field_o       <= 1'b0;
      end else begin
         field_o       <= fld;
         line_start_o  <= adv_q && (seg == SEG_LINE) && (us == '0);
         field_start_o <= adv_q && (seg == SEG_PRE) && (grp == '0) && (us == '0);
         if (adv_q) begin
            unique case (lvl)
               LVL_SYNC:  amp_o <= CODE_SYNC;
               LVL_BLANK: amp_o <= CODE_BLANK;
               default:   amp_o <= pix_code;
            endcase
         end
      end
   end

endmodule

// File: rtl/atvs_chk.sv
module atvs_chk #(
   parameter int PIX_US = 52
) (
   input logic       clk_i,
   input logic       rst_i,
   input logic       tick_i,
   input logic       adv_q,
   input logic       smp_req_o,
   input logic [2:0] amp_o,
   input logic       line_start_o,
   input logic       field_start_o,
   input logic       field_o
);
   int pix_run;

   always_ff @(posedge clk_i) begin
      if (rst_i || line_start_o) pix_run <= 0;
      else if (smp_req_o)        pix_run <= pix_run + 1;
   end

   assert_reset_state_R1: assert property (@(posedge clk_i)
      rst_i |=> (amp_o == 3'd0 && !smp_req_o && !line_start_o && !field_start_o && !field_o));

   assert_hold_between_ticks_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(adv_q) && !$past(rst_i)) |-> $stable(amp_o));

   assert_line_sync_tip_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      line_start_o |-> (amp_o == 3'd0));

   assert_line_pulse_single_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      line_start_o |=> !line_start_o);

   assert_req_follows_tick_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      smp_req_o |-> $past(tick_i));

   assert_req_per_line_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      pix_run <= PIX_US);

   assert_field_toggle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      field_start_o |-> (field_o != $past(field_o) && amp_o == 3'd0));

endmodule

bind atv_field_seq atvs_chk #(.PIX_US(PIX_US)) i_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .tick_i       (tick_i),
   .adv_q        (adv_q),
   .smp_req_o    (smp_req_o),
   .amp_o        (amp_o),
   .line_start_o (line_start_o),
   .field_start_o(field_start_o),
   .field_o      (field_o)
);

// File: tb/test_atv_field_seq.sv
module test_atv_field_seq;

   localparam int F0    = 5 * 32 + 5 * 32 + 5 * 32 + 305 * 64;
   localparam int F1    = 6 * 32 + 5 * 32 + 5 * 32 + 305 * 64;
   localparam int FRAME = F0 + F1;

   logic              clk = 1'b0;
   logic              rst_i = 1'b1;
   logic              tick_i = 1'b1;
   logic              smp_valid_i = 1'b0;
   logic signed [7:0] smp_i = '0;
   logic              smp_req_o;
   logic [2:0]        amp_o;
   logic              line_start_o;
   logic              field_start_o;
   logic              field_o;

   always #10 clk = ~clk;

   atv_field_seq i_atv_field_seq (
      .clk_i        (clk),
      .rst_i        (rst_i),
      .tick_i       (tick_i),
      .smp_valid_i  (smp_valid_i),
      .smp_i        (smp_i),
      .smp_req_o    (smp_req_o),
      .amp_o        (amp_o),
      .line_start_o (line_start_o),
      .field_start_o(field_start_o),
      .field_o      (field_o)
   );

   int    checks = 0;
   int    fails = 0;
   bit    done = 0;

   // behavioural model: absolute slot number inside the frame
   int    mt;
   bit    madv;
   int    eamp;
   string etag;
   bit    esol, efs, efld, in_rst;

   int    gc = 0;
   logic [15:0] lfsr = 16'hACE1;
   int    reqs, sols, last_fs_cyc;
   bit    have_fs, all_tick;

   task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s got=%0d exp=%0d (slot %0d)", tag, what, got, exp, mt);
      end
   endtask

   function automatic void classify(input int t, output int rg, output int kd,
                                    output bit ls, output bit fs);
      int o, pre, l;
      o   = (t >= F0) ? t - F0 : t;
      pre = ((t >= F0) ? 6 : 5) * 32;
      fs  = (o == 0);
      ls  = 1'b0;
      if (o < pre) begin
         rg = 0; kd = ((o % 32) < 2) ? 0 : 1;
      end else if (o < pre + 160) begin
         rg = 1; kd = (((o - pre) % 32) < 27) ? 0 : 1;
      end else if (o < pre + 320) begin
         rg = 2; kd = (((o - pre - 160) % 32) < 2) ? 0 : 1;
      end else begin
         rg = 3;
         l  = (o - pre - 320) % 64;
         ls = (l == 0);
         if (l < 4)       kd = 0;
         else if (l < 10) kd = 1;
         else if (l < 62) kd = 2;
         else             kd = 1;
      end
   endfunction

   function automatic int exp_code(input logic signed [7:0] s);
      int  a;
      real x;
      int  q;
      a = (s < 0) ? -int'(s) : int'(s);
      x = a * 6.0 / 64.0;
      q = int'($floor(x + 0.5)) + 1;
      return (q > 7) ? 7 : q;
   endfunction

   function automatic logic signed [7:0] corner(input int k);
      case (k)
         0: return 8'sd0;
         1: return 8'sd64;
         2: return -8'sd64;
         3: return 8'sd32;
         4: return -8'sd128;
         5: return 8'sd5;
         6: return 8'sd6;
         7: return 8'sd16;
         8: return -8'sd16;
         default: return 8'sd127;
      endcase
   endfunction

   task automatic model_reset();
      mt = 0; madv = 0; eamp = 0; etag = "R1";
      esol = 0; efs = 0; efld = 0; in_rst = 1;
      have_fs = 0; reqs = 0; sols = 0;
   endtask

   task automatic step(input bit nrst, input bit ntick);
      int rg, kd;
      bit ls, fs, nvalid;
      logic signed [7:0] nsmp;
      string ctag;
      ctag = in_rst ? "R1" : "R10";
      classify(mt, rg, kd, ls, fs);
      chk(smp_req_o === (madv && kd == 2), in_rst ? "R1" : "R7", "smp_req_o",
          int'(smp_req_o), int'(madv && kd == 2));
      chk(amp_o === 3'(eamp), etag, "amp_o", int'(amp_o), eamp);
      chk(line_start_o === esol, ctag, "line_start_o", int'(line_start_o), int'(esol));
      chk(field_start_o === efs, ctag, "field_start_o", int'(field_start_o), int'(efs));
      chk(field_o === efld, ctag, "field_o", int'(field_o), int'(efld));

      if (!in_rst && field_start_o) begin
         if (have_fs) begin
            chk(reqs == 305 * 52, "R7", "requests per field", reqs, 305 * 52);
            chk(sols == 305, "R6", "lines per field", sols, 305);
            if (all_tick)
               chk(gc - last_fs_cyc == (field_o ? F0 : F1), "R11", "field length",
                   gc - last_fs_cyc, field_o ? F0 : F1);
         end
         have_fs = 1; all_tick = 1; last_fs_cyc = gc; reqs = 0; sols = 0;
      end
      if (smp_req_o)    reqs++;
      if (line_start_o) sols++;

      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nvalid = (lfsr[2:0] != 3'd0);
      nsmp   = (gc < 3000) ? corner(gc % 10) : signed'(lfsr[15:8]);
      rst_i       <= nrst;
      tick_i      <= ntick;
      smp_valid_i <= nvalid;
      smp_i       <= nsmp;
      if (!ntick) all_tick = 0;
      gc++;

      if (nrst) begin
         model_reset();
      end else begin
         in_rst = 0;
         efld = (mt >= F0);
         if (madv) begin
            esol = ls; efs = fs;
            if (kd == 0 || kd == 1) begin
               eamp = kd;
               etag = (rg == 0) ? "R3" : (rg == 1) ? "R4" : (rg == 2) ? "R5" : "R6";
            end else begin
               eamp = nvalid ? exp_code(nsmp) : 3;
               etag = nvalid ? "R8" : "R9";
            end
         end else begin
            esol = 0; efs = 0; etag = "R2";
         end
         madv = ntick;
         if (ntick) mt = (mt + 1) % FRAME;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      model_reset();
      // reset with ticks arriving: they must be ignored (R1)
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
      for (int i = 0; i < 700; i++) step(1'b0, 1'b1);
      // reset in the middle of a run
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
      // a tick on every clock: more than a whole frame (R11 lengths)
      for (int i = 0; i < 60100; i++) step(1'b0, 1'b1);
      // gaps between ticks (R2)
      for (int i = 0; i < 62000; i++) step(1'b0, (i % 3) != 2);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete got=0 exp=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule